// File: doc/BRIEF.md
# Link Retraining Handshake Sequencer

This block sits on the serializer side of a link that alternates between a control-channel phase and a video phase. While the control channel is open, the block waits. It leaves that phase only on one of three close strobes: a start-timeout expiry, an end-timeout expiry or an end-of-frame event. The vertical sync input plays no part in closing the channel.

Once the channel closes, the block opens a handshake window of a fixed number of pixel clocks. During that window it listens on the receive symbol interface for a lock symbol from the far end. The far end sends that symbol only when its decode-error count from the last video session stayed within its threshold. If the lock symbol is seen inside the window, the far end is taken to be locked and a short training burst follows. If it is not seen, a long burst follows.

Either burst is followed by exactly three sync symbols. In the cycle after the third sync symbol, video enable is raised. It stays high until the control channel opens again. Video data that becomes valid while retraining is still running sets a sticky overrun flag, which signals possible data loss.

Top module: `retrain_seq`

## Requirements
- R1: After reset the block is in the control phase: tx_valid, video_enable and overrun are all 0.
- R2: In the control phase only a 1 on start_tmo, end_tmo or end_frame closes the channel. vsync, rx inputs and vid_valid have no effect there, and tx_valid and video_enable stay 0.
- R3: The handshake window starts on the clock edge that samples a close strobe and lasts exactly HS_WIN cycles, with tx_valid held 0 throughout.
- R4: If rx_valid is 1 with rx_symbol equal to LOCK_SYM in any window cycle, including the last one, exactly SHORT_LEN cycles of tx_valid=1 with tx_symbol=TRAIN_SYM follow the window.
- R5: If no lock symbol arrives inside the window, exactly LONG_LEN training cycles follow. A lock symbol received before the close or after the window does not count.
- R6: After training, exactly three cycles of tx_valid=1 with tx_symbol=SYNC_SYM are sent, directly after the last training symbol.
- R7: video_enable becomes 1 in the cycle after the third sync symbol. It stays 1, with tx_valid 0, until ctrl_open is sampled high, and returns to 0 in the next cycle.
- R8: overrun is set one cycle after vid_valid is sampled high during the window, training or sync cycles. It stays set until ctrl_open ends the video phase. vid_valid during the control or video phase does not set it.
- R9: A ctrl_open pulse received while retraining is in progress is ignored, and the sequence completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_open | input | 1 | Strobe: control channel opens, ends the video phase |
| start_tmo | input | 1 | Strobe: start-timeout expiry closes the control channel |
| end_tmo | input | 1 | Strobe: end-timeout expiry closes the control channel |
| end_frame | input | 1 | Strobe: end-of-frame indication closes the control channel |
| vsync | input | 1 | Vertical sync, has no effect on sequencing |
| rx_valid | input | 1 | Receive symbol valid |
| rx_symbol | input | SYM_W | Receive symbol from the far end |
| vid_valid | input | 1 | Video data is available |
| tx_valid | output | 1 | Transmit symbol valid |
| tx_symbol | output | SYM_W | Transmit symbol: training or sync |
| video_enable | output | 1 | Video phase enabled |
| overrun | output | 1 | Sticky: video data arrived before retraining completed |

## Verification
The assertions check four properties on every cycle:
- the control phase cannot end without a close strobe;
- the handshake window never transmits;
- video enable is held, never overlaps a transmitted symbol, and drops only on ctrl_open;
- the overrun flag is sticky.

Only the bench's scenarios can show that the burst length depends on lock reception within the window. The bench sweeps every window position plus positions just outside it, over all three close strobes. The same holds for the exact count of three sync symbols, the timing of the video-enable edge, and overrun being set only by data in the retraining phases.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [2:0] {
        ST_CTRL  = 3'd0,
        ST_HS    = 3'd1,
        ST_TRAIN = 3'd2,
        ST_SYNC  = 3'd3,
        ST_VIDEO = 3'd4
    } rs_state_e;

    localparam int unsigned NUM_SYNC = 3;
endpackage

// File: rtl/rs_lock_det.sv
module rs_lock_det
    import rs_pkg::*;
#(
    parameter int unsigned SYM_W    = 8,
    parameter logic [SYM_W-1:0] LOCK_SYM = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             listen,
    input  logic             rx_valid,
    input  logic [SYM_W-1:0] rx_symbol,
    output logic             locked
);
    logic seen_d, seen_q;
    logic hit;

    always_comb begin
        hit    = listen && rx_valid && (rx_symbol == LOCK_SYM);
        seen_d = seen_q;
        if (clear)    seen_d = 1'b0;
        else if (hit) seen_d = 1'b1;
        locked = seen_q || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end
endmodule

// File: rtl/rs_tx_mux.sv
module rs_tx_mux
    import rs_pkg::*;
#(
    parameter int unsigned SYM_W     = 8,
    parameter logic [SYM_W-1:0] TRAIN_SYM = 8'h55,
    parameter logic [SYM_W-1:0] SYNC_SYM  = 8'hBC
) (
    input  rs_state_e        st,
    output logic             tx_valid,
    output logic [SYM_W-1:0] tx_symbol
);
    always_comb begin
        tx_valid  = 1'b0;
        tx_symbol = '0;
        case (st)
            ST_TRAIN: begin
                tx_valid  = 1'b1;
                tx_symbol = TRAIN_SYM;
            end
            ST_SYNC: begin
                tx_valid  = 1'b1;
                tx_symbol = SYNC_SYM;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/retrain_seq.sv
module retrain_seq
    import rs_pkg::*;
#(
    parameter int unsigned SYM_W     = 8,
    parameter int unsigned HS_WIN    = 16,
    parameter int unsigned SHORT_LEN = 8,
    parameter int unsigned LONG_LEN  = 64,
    parameter logic [SYM_W-1:0] LOCK_SYM  = 8'hA5,
    parameter logic [SYM_W-1:0] TRAIN_SYM = 8'h55,
    parameter logic [SYM_W-1:0] SYNC_SYM  = 8'hBC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_open,
    input  logic             start_tmo,
    input  logic             end_tmo,
    input  logic             end_frame,
    input  logic             vsync,
    input  logic             rx_valid,
    input  logic [SYM_W-1:0] rx_symbol,
    input  logic             vid_valid,
    output logic             tx_valid,
    output logic [SYM_W-1:0] tx_symbol,
    output logic             video_enable,
    output logic             overrun
);
    localparam int unsigned MAX_A = (HS_WIN > LONG_LEN) ? HS_WIN : LONG_LEN;
    localparam int unsigned MAX_L = (MAX_A > SHORT_LEN) ? MAX_A : SHORT_LEN;
    localparam int unsigned CW    = $clog2(MAX_L + 1);

    typedef struct packed {
        rs_state_e     st;
        logic [CW-1:0] cnt;
        logic          ovr;
    } regs_t;

    regs_t     r_d, r_q;
    rs_state_e st_q;
    logic      close_any;
    logic      locked;
    logic      vsync_unused;

    assign st_q         = r_q.st;
    assign vsync_unused = vsync;

    rs_lock_det #(.SYM_W(SYM_W), .LOCK_SYM(LOCK_SYM)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (r_q.st == ST_CTRL),
        .listen   (r_q.st == ST_HS),
        .rx_valid (rx_valid),
        .rx_symbol(rx_symbol),
        .locked   (locked)
    );

    rs_tx_mux #(.SYM_W(SYM_W), .TRAIN_SYM(TRAIN_SYM), .SYNC_SYM(SYNC_SYM)) u_mux (
        .st       (r_q.st),
        .tx_valid (tx_valid),
        .tx_symbol(tx_symbol)
    );

    always_comb begin
        close_any = start_tmo || end_tmo || end_frame;
        r_d       = r_q;
        case (r_q.st)
            ST_CTRL: begin
                if (close_any) begin
                    r_d.st  = ST_HS;
                    r_d.cnt = CW'(HS_WIN - 1);
                end
            end
            ST_HS: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_TRAIN;
                    r_d.cnt = locked ? CW'(SHORT_LEN - 1) : CW'(LONG_LEN - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_TRAIN: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_SYNC;
                    r_d.cnt = CW'(NUM_SYNC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SYNC: begin
                if (r_q.cnt == '0) r_d.st  = ST_VIDEO;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_VIDEO: begin
                if (ctrl_open) begin
                    r_d.st  = ST_CTRL;
                    r_d.ovr = 1'b0;
                end
            end
            default: r_d.st = ST_CTRL;
        endcase
        if (vid_valid && (r_q.st == ST_HS || r_q.st == ST_TRAIN || r_q.st == ST_SYNC))
            r_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_CTRL;
            r_q.cnt <= '0;
            r_q.ovr <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign video_enable = (r_q.st == ST_VIDEO);
    assign overrun      = r_q.ovr;
endmodule

// File: rtl/rs_chk.sv
module rs_chk
    import rs_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input rs_state_e st,
    input logic      ctrl_open,
    input logic      start_tmo,
    input logic      end_tmo,
    input logic      end_frame,
    input logic      tx_valid,
    input logic      video_enable,
    input logic      overrun
);
    p_no_spurious_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CTRL && !(start_tmo || end_tmo || end_frame)) |=> (st == ST_CTRL));

    p_hs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HS) |-> !tx_valid);

    p_vid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (video_enable && !ctrl_open) |=> video_enable);

    p_vid_no_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        video_enable |-> !tx_valid);

    p_vid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (video_enable && ctrl_open) |=> !video_enable);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(video_enable && ctrl_open)) |=> overrun);
endmodule

bind retrain_seq rs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st_q),
    .ctrl_open   (ctrl_open),
    .start_tmo   (start_tmo),
    .end_tmo     (end_tmo),
    .end_frame   (end_frame),
    .tx_valid    (tx_valid),
    .video_enable(video_enable),
    .overrun     (overrun)
);

// File: tb/sim_retrain_seq.sv
module sim_retrain_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SYM_W = 8;
    localparam int HS_WIN = 4;
    localparam int SHORT_LEN = 3;
    localparam int LONG_LEN = 7;
    localparam logic [7:0] LOCK_SYM = 8'hA5;
    localparam logic [7:0] TRAIN_SYM = 8'h55;
    localparam logic [7:0] SYNC_SYM = 8'hBC;

    logic clk = 0, rst_n = 0;
    logic ctrl_open = 0, start_tmo = 0, end_tmo = 0, end_frame = 0, vsync = 0;
    logic rx_valid = 0, vid_valid = 0;
    logic [SYM_W-1:0] rx_symbol = '0;
    logic tx_valid, video_enable, overrun;
    logic [SYM_W-1:0] tx_symbol;
    int n_chk = 0, n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retrain_seq #(.SYM_W(SYM_W), .HS_WIN(HS_WIN), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
                  .LOCK_SYM(LOCK_SYM), .TRAIN_SYM(TRAIN_SYM), .SYNC_SYM(SYNC_SYM)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_open(ctrl_open), .start_tmo(start_tmo),
        .end_tmo(end_tmo), .end_frame(end_frame), .vsync(vsync), .rx_valid(rx_valid),
        .rx_symbol(rx_symbol), .vid_valid(vid_valid), .tx_valid(tx_valid),
        .tx_symbol(tx_symbol), .video_enable(video_enable), .overrun(overrun));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 start_tmo, 1 end_tmo, 2 end_frame. lpos: window index of lock symbol,
    // -1 none, HS_WIN means first cycle after window. ovr_at: window index of vid_valid, -1 none.
    task automatic run(input int kind, input int lpos, input int ovr_at,
                       input bit pre_lock, input bit mid_open);
        int exp_len;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R2 idle tx_valid", tx_valid, 0);
            chk("R2 idle video_enable", video_enable, 0);
            vsync = c[0];
            rx_valid = pre_lock && (c == 1);
            rx_symbol = LOCK_SYM;
            vid_valid = (c == 2);
        end
        @(negedge clk);
        chk("R2 idle tx_valid", tx_valid, 0);
        chk("R8 no overrun from control phase", overrun, 0);
        rx_valid = 0; vid_valid = 0; vsync = 0;
        start_tmo = (kind == 0); end_tmo = (kind == 1); end_frame = (kind == 2);
        for (int i = 0; i < HS_WIN; i++) begin
            @(negedge clk);
            chk("R3 window tx_valid", tx_valid, 0);
            chk("R3 window video_enable", video_enable, 0);
            start_tmo = 0; end_tmo = 0; end_frame = 0;
            rx_valid = (i == lpos);
            vid_valid = (i == ovr_at);
            ctrl_open = mid_open && (i == 0);
        end
        exp_len = (lpos >= 0 && lpos < HS_WIN) ? SHORT_LEN : LONG_LEN;
        for (int k = 0; k < exp_len; k++) begin
            @(negedge clk);
            if (exp_len == SHORT_LEN) begin
                chk("R4 short train valid", tx_valid, 1);
                chk("R4 short train symbol", tx_symbol, TRAIN_SYM);
            end else begin
                chk("R5 long train valid", tx_valid, 1);
                chk("R5 long train symbol", tx_symbol, TRAIN_SYM);
            end
            rx_valid = (lpos == HS_WIN) && (k == 0);
            vid_valid = 0; ctrl_open = 0;
        end
        rx_valid = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 sync valid", tx_valid, 1);
            chk("R6 sync symbol", tx_symbol, SYNC_SYM);
        end
        @(negedge clk);
        chk(mid_open ? "R9 video after ignored open" : "R7 video_enable rise", video_enable, 1);
        chk("R7 tx idle in video", tx_valid, 0);
        chk("R8 overrun flag", overrun, (ovr_at >= 0) ? 1 : 0);
        vid_valid = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 video_enable held", video_enable, 1);
            chk("R8 overrun unchanged in video", overrun, (ovr_at >= 0) ? 1 : 0);
            vid_valid = (k < 2);
            ctrl_open = (k == 2);
        end
        @(negedge clk);
        ctrl_open = 0;
        chk("R7 video_enable drop", video_enable, 0);
        chk("R8 overrun cleared", overrun, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset tx_valid", tx_valid, 0);
        chk("R1 reset video_enable", video_enable, 0);
        chk("R1 reset overrun", overrun, 0);
        rst_n = 1;
        // R2: long idle with vsync toggles and no close strobe
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            vsync = ~vsync;
            chk("R2 vsync ignored", tx_valid | video_enable, 0);
        end
        for (int kind = 0; kind < 3; kind++)
            for (int lpos = -1; lpos <= HS_WIN; lpos++)
                run(kind, lpos, -1, 1'b0, 1'b0);
        run(0, -1, -1, 1'b1, 1'b0);            // R5 lock before close ignored
        for (int o = 0; o < HS_WIN; o++)
            run(1, o % 2 == 0 ? 1 : -1, o, 1'b0, 1'b0);  // R8
        run(2, 2, -1, 1'b0, 1'b1);             // R9
        run(0, -1, -1, 1'b0, 1'b1);            // R9
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule